// File: doc/BRIEF.md
# Windowed Watchdog Timer

This peripheral supervises software with a 12-bit down-counter. A divider turns the system clock into a slow periodic tick, nominally 256 per second, and the counter steps down by one on each tick. Software must restart the counter before it reaches zero. It may not restart too early either. A restart while the counter is still above a programmed window value is treated as a failure, in the same way as a timeout.

A small word-addressed register bus gives access to three registers. The control register accepts a restart command, guarded by a key byte. The configuration register can be written once after reset and sets the reload value, the window value, the enable and halt flags, and the fault routing. The status register records underflow and window faults, and a read clears it. A fault can raise an interrupt level, a one-cycle reset request, or both. A separate output selects whether the reset covers only the processor or the whole system.

The configuration bits used throughout are as follows. Reload is bits 11:0. Interrupt enable is bit 12. Reset enable is bit 13. Processor-only reset is bit 14. Disable is bit 15. Window value is bits 27:16. Debug freeze is bit 28. Idle freeze is bit 29. Bits 31:30 always read as zero.

Top module: `wwdt_top`

## Requirements
- R1: After reset, the configuration register (byte address 0x4) reads 0x3FFF2FFF and the status register (address 0x8) reads 0. The interrupt and reset-request outputs are low, and the counter holds 0xFFF.
- R2: Only the first configuration write after reset takes effect. Every later write leaves the register unchanged. Bits 31:30 read as zero. The accepted write also loads the counter with the new reload value.
- R3: While the counter runs, it decrements once per tick. From a load of N, it underflows on tick N+1. An underflow sets status bit 0.
- R4: A control write (address 0x0) with key 0xA5 in bits 31:24 and bit 0 set reloads the counter from the reload field. A write with any other key has no effect.
- R5: A valid restart while the counter is greater than the window value sets status bit 1, the window fault.
- R6: A valid restart while the counter is at or below the window value raises no fault.
- R7: The fault interrupt output is high while any status bit is set and interrupt enable (bit 12) is 1. It stays low otherwise.
- R8: With reset enable (bit 13) set, each fault produces a reset request exactly one cycle long. The processor-only output follows bit 14.
- R9: With disable (bit 15) set, the counter holds, no fault occurs, and restarts have no effect.
- R10: The counter holds while core_idle_i is high and bit 29 is set. It also holds while dbg_halt_i is high and bit 28 is set.
- R11: A read of the status register clears both of its bits.
- R12: On underflow, the counter reloads from the reload field and keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address (0x0, 0x4, 0x8) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_sel is high |
| core_idle_i | input | 1 | Processor idle indication |
| dbg_halt_i | input | 1 | Processor halted by debugger |
| fault_irq_o | output | 1 | Fault interrupt level |
| rst_req_o | output | 1 | One-cycle reset request |
| rst_proc_only_o | output | 1 | Reset scope: 1 = processor only |

## Verification
The bench sets TICK_DIV to 4, so a tick occurs every four clock cycles and the key keeps its default of 0xA5. At this setting even the full-scale 4096-tick timeout from the reset configuration ends within about 16k cycles. Small reload and window values then make the early-restart, late-restart and repeated-underflow orderings cheap to place. Fault times are checked against a window one tick wide, because the tick phase runs free of the register writes.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;
  localparam int CNT_W = 12;

  localparam logic [3:0] ADDR_CTRL = 4'h0;
  localparam logic [3:0] ADDR_MODE = 4'h4;
  localparam logic [3:0] ADDR_STAT = 4'h8;

  // configuration layout, MSB first
  typedef struct packed {
    logic [1:0]       rsvd;
    logic             idle_frz;
    logic             dbg_frz;
    logic [CNT_W-1:0] window;
    logic             dis;
    logic             proc_only;
    logic             rst_en;
    logic             irq_en;
    logic [CNT_W-1:0] reload;
  } wdog_cfg_t;

  localparam logic [31:0] CFG_RESET = 32'h3FFF_2FFF;
  localparam logic [31:0] CFG_MASK  = 32'h3FFF_FFFF;
endpackage

// File: rtl/wwdt_tick.sv
module wwdt_tick #(
  parameter int TICK_DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int PW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] div_q, div_d;
  logic          tick_q, tick_d;

  always_comb begin
    div_d  = (div_q == LAST) ? '0 : div_q + 1'b1;
    tick_d = (div_q == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      div_q  <= div_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/wwdt_core.sv
module wwdt_core
  import wwdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic [CNT_W-1:0] window_i,
  input  logic             dis_i,
  input  logic             idle_frz_i,
  input  logic             dbg_frz_i,
  input  logic             core_idle_i,
  input  logic             dbg_halt_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             restart_i,
  output logic             unf_evt_o,
  output logic             win_evt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run, restart_eff;

  always_comb begin
    run         = !dis_i && !(core_idle_i && idle_frz_i) && !(dbg_halt_i && dbg_frz_i);
    restart_eff = restart_i && !dis_i;
    win_evt_o   = restart_eff && (cnt_q > window_i);
    unf_evt_o   = !load_i && !restart_eff && tick_i && run && (cnt_q == '0);
    cnt_d       = cnt_q;
    if (load_i)
      cnt_d = load_val_i;
    else if (restart_eff)
      cnt_d = reload_i;
    else if (tick_i && run)
      cnt_d = (cnt_q == '0) ? reload_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '1;
    else        cnt_q <= cnt_d;
  end

  // R3
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && run && cnt_q != '0 && !load_i && !restart_eff) |=> cnt_q == $past(cnt_q) - 1'b1);
  // R9
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load_i && !restart_eff) |=> $stable(cnt_q));
  // R12
  unf_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf_evt_o |=> cnt_q == $past(reload_i));
endmodule

// File: rtl/wwdt_regs.sv
module wwdt_regs
  import wwdt_pkg::*;
#(
  parameter logic [7:0] KEY = 8'hA5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [3:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             unf_evt_i,
  input  logic             win_evt_i,
  output wdog_cfg_t        cfg_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             restart_o,
  output logic [1:0]       status_o
);
  wdog_cfg_t  cfg_q, cfg_d;
  logic       locked_q, locked_d;
  logic [1:0] stat_q, stat_d;
  logic       cfg_we, stat_rd;

  always_comb begin
    cfg_we     = bus_sel && bus_wr && (bus_addr == ADDR_MODE) && !locked_q;
    stat_rd    = bus_sel && !bus_wr && (bus_addr == ADDR_STAT);
    restart_o  = bus_sel && bus_wr && (bus_addr == ADDR_CTRL) &&
                 (bus_wdata[31:24] == KEY) && bus_wdata[0];
    load_o     = cfg_we;
    load_val_o = bus_wdata[CNT_W-1:0];
    cfg_d      = cfg_we ? wdog_cfg_t'(bus_wdata & CFG_MASK) : cfg_q;
    locked_d   = locked_q || cfg_we;
    stat_d     = (stat_rd ? 2'b00 : stat_q) | {win_evt_i, unf_evt_i};
    unique case (bus_addr)
      ADDR_MODE: bus_rdata = cfg_q;
      ADDR_STAT: bus_rdata = {30'd0, stat_q};
      default:   bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= wdog_cfg_t'(CFG_RESET);
      locked_q <= 1'b0;
      stat_q   <= 2'b00;
    end else begin
      cfg_q    <= cfg_d;
      locked_q <= locked_d;
      stat_q   <= stat_d;
    end
  end

  assign cfg_o    = cfg_q;
  assign status_o = stat_q;

  // R2
  mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && bus_sel && bus_wr) |=> $stable(cfg_q));
  // R11
  stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !unf_evt_i && !win_evt_i) |=> stat_q == 2'b00);
endmodule

// File: rtl/wwdt_top.sv
module wwdt_top
  import wwdt_pkg::*;
#(
  parameter int         TICK_DIV = 128,
  parameter logic [7:0] KEY      = 8'hA5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        core_idle_i,
  input  logic        dbg_halt_i,
  output logic        fault_irq_o,
  output logic        rst_req_o,
  output logic        rst_proc_only_o
);
  wdog_cfg_t        cfg;
  logic             tick, load, restart, unf_evt, win_evt;
  logic [CNT_W-1:0] load_val;
  logic [1:0]       status;
  logic             rreq_q, rreq_d;

  wwdt_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  wwdt_regs #(.KEY(KEY)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .unf_evt_i(unf_evt), .win_evt_i(win_evt),
    .cfg_o(cfg), .load_o(load), .load_val_o(load_val),
    .restart_o(restart), .status_o(status)
  );

  wwdt_core u_core (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .reload_i(cfg.reload), .window_i(cfg.window), .dis_i(cfg.dis),
    .idle_frz_i(cfg.idle_frz), .dbg_frz_i(cfg.dbg_frz),
    .core_idle_i(core_idle_i), .dbg_halt_i(dbg_halt_i),
    .load_i(load), .load_val_i(load_val), .restart_i(restart),
    .unf_evt_o(unf_evt), .win_evt_o(win_evt)
  );

  always_comb rreq_d = (unf_evt || win_evt) && cfg.rst_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rreq_q <= 1'b0;
    else        rreq_q <= rreq_d;
  end

  assign rst_req_o       = rreq_q;
  assign fault_irq_o     = cfg.irq_en && (status != 2'b00);
  assign rst_proc_only_o = cfg.proc_only;

  // R5
  win_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_evt |=> status[1]);
  // R8
  rreq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> $past(unf_evt || win_evt));
endmodule

// File: tb/tb_wwdt_top.sv
module tb_wwdt_top;
  localparam int DIV = 4;

  logic        clk, rst_n, bus_sel, bus_wr, core_idle_i, dbg_halt_i;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        fault_irq_o, rst_req_o, rst_proc_only_o;

  int checks = 0;
  int errors = 0;

  typedef struct { logic [31:0] exp; string tag; } sb_item_t;
  sb_item_t sb_q[$];
  event     mon_ev;

  wwdt_top #(.TICK_DIV(DIV), .KEY(8'hA5)) dut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(mon_ev) begin
    sb_item_t it;
    it = sb_q.pop_front();
    chk(bus_rdata === it.exp, it.tag, bus_rdata, it.exp);
  end

  task automatic do_reset();
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    core_idle_i = 0; dbg_halt_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    sb_item_t it;
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    #1 -> mon_ev;
    @(negedge clk);
    bus_sel = 0;
  endtask

  function automatic logic [31:0] mk(input int rl, input int win, input bit irq,
                                     input bit rst, input bit proc, input bit dis,
                                     input bit dfz, input bit ifz);
    return {2'b00, ifz, dfz, 12'(win), dis, proc, rst, irq, 12'(rl)};
  endfunction

  task automatic wait_irq(output int n, input int lim);
    n = 0;
    while (!fault_irq_o && n < lim) begin @(negedge clk); n++; end
  endtask

  initial begin
    #1_500_000;
    errors++;
    checks++;
    $display("FAIL watchdog: run hung, actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, pulses, first;
    // R1 reset state
    do_reset();
    rd(4'h4, 32'h3FFF_2FFF, "R1 cfg reset");
    rd(4'h8, 32'h0, "R1 status reset");
    chk(fault_irq_o == 0 && rst_req_o == 0 && rst_proc_only_o == 0, "R1 outputs", 1, 0);

    // R8: default config underflows from 0xFFF with a single reset pulse, no irq (R7)
    n = 0; pulses = 0; first = 0;
    while (n < 4097*DIV) begin
      @(negedge clk); n++;
      if (rst_req_o) begin pulses++; if (first == 0) first = n; end
      if (fault_irq_o) chk(0, "R7 irq while disabled", 1, 0);
    end
    chk(pulses == 1, "R8 reset pulse count", pulses, 1);
    chk(first >= 4095*DIV+1 && first <= 4096*DIV + 1, "R3 full-scale timeout", first, 4096*DIV);
    rd(4'h8, 32'h1, "R3 underflow flag");

    // R2 lock, masking, and R8 scope bit
    do_reset();
    wr(4'h4, 32'hC000_0000 | mk(200, 100, 0, 0, 1, 0, 0, 0));
    wr(4'h4, mk(7, 3, 1, 1, 0, 0, 1, 1));
    rd(4'h4, mk(200, 100, 0, 0, 1, 0, 0, 0), "R2 locked cfg");
    chk(rst_proc_only_o == 1, "R8 proc-only output", rst_proc_only_o, 1);

    // R3 timeout window from load, R7 irq, R11 clear
    do_reset();
    wr(4'h4, mk(10, 10, 1, 0, 0, 0, 0, 0));
    wait_irq(n, 200);
    chk(n >= 10*DIV+1 && n <= 11*DIV, "R3 reload 10 timeout", n, 11*DIV);
    rd(4'h8, 32'h1, "R3 status after underflow");
    chk(fault_irq_o == 0, "R11 irq cleared by read", fault_irq_o, 0);
    rd(4'h8, 32'h0, "R11 status cleared");

    // R5 / R6 / R4 / R12 window sequence
    do_reset();
    wr(4'h4, mk(20, 5, 1, 1, 0, 0, 0, 0));
    wr(4'h0, 32'hA500_0001);
    chk(fault_irq_o == 1, "R7 irq on window fault", fault_irq_o, 1);
    rd(4'h8, 32'h2, "R5 early restart");
    repeat (70) @(negedge clk);
    wr(4'h0, 32'hA500_0001);
    rd(4'h8, 32'h0, "R6 restart in window");
    repeat (70) @(negedge clk);
    wr(4'h0, 32'h5A00_0001);
    repeat (40) @(negedge clk);
    rd(4'h8, 32'h1, "R4 wrong key ignored");
    repeat (90) @(negedge clk);
    rd(4'h8, 32'h1, "R12 runs on after underflow");

    // R9 disable
    do_reset();
    wr(4'h4, mk(3, 0, 1, 1, 0, 1, 0, 0));
    n = 0;
    repeat (100) begin @(negedge clk); if (fault_irq_o || rst_req_o) n++; end
    wr(4'h0, 32'hA500_0001);
    chk(n == 0, "R9 no fault when disabled", n, 0);
    rd(4'h8, 32'h0, "R9 restart ignored");

    // R10 idle freeze
    do_reset();
    core_idle_i = 1;
    wr(4'h4, mk(10, 10, 1, 0, 0, 0, 0, 1));
    repeat (200) @(negedge clk);
    chk(fault_irq_o == 0, "R10 idle freeze", fault_irq_o, 0);
    core_idle_i = 0;
    wait_irq(n, 200);
    chk(n >= 10*DIV && n <= 11*DIV, "R10 resume after idle", n, 11*DIV);

    // R10 debug freeze
    do_reset();
    dbg_halt_i = 1;
    wr(4'h4, mk(10, 10, 1, 0, 0, 0, 1, 0));
    repeat (200) @(negedge clk);
    chk(fault_irq_o == 0, "R10 debug freeze", fault_irq_o, 0);
    dbg_halt_i = 0;
    wait_irq(n, 200);
    chk(n >= 10*DIV && n <= 11*DIV, "R10 resume after debug", n, 11*DIV);

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule